// File: doc/BRIEF.md
# Windowed Haar Lifting Forward Transform

This block computes a one-level integer Haar wavelet transform on a stream of signed samples, one line at a time, using lifting. Each accepted sample alternates between an even holding register and the odd slot. When the odd sample arrives, a predict stage subtracts the held even sample from it to form the detail coefficient. An update stage then adds the arithmetically halved detail back to the even sample to form the approximation coefficient. The update uses the detail and never the raw odd sample, so the pair can be undone exactly in integers.

The padded line has one zero pair at its front and one at its back, which is two zero samples on each side. This lets the line split into whole windows of `WIN_LEN` samples, so a 256-sample line becomes 26 windows of ten samples each. The block emits each padding pair as a (0, 0) coefficient pair. It counts pairs from the start of the padded line and flags the last pair of every window. The pair counter and the even/odd pairing both restart at the first sample of every line.

An `enable` input acts as a clock enable for the whole block. Input samples count as accepted only when both `enable` and `in_valid` are high.

Top module: `haar_lift_window`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_approx`, `out_detail` and `out_eow` are all zero, and the block clears its pairing and line position.
- R2: Accepted samples are paired in order (even first, then odd). Pairing restarts at sample 0 of each line of `LINE_LEN` samples (an even count), so every line's pairs are (s0,s1), (s2,s3), and so on.
- R3: For each real pair, `out_detail` (two's complement, `SAMPLE_W+1` bits) equals odd minus even exactly, and never overflows.
- R4: For each real pair, `out_approx` (two's complement, `SAMPLE_W` bits) equals even plus floor(detail/2), where the halving is an arithmetic right shift. The result always fits in `SAMPLE_W` bits.
- R5: For each real pair, `out_valid` is high for exactly one cycle, in the clock edge that accepts the odd sample. A real pair is never emitted in the same edge as a padding pair.
- R6: The clock edge that accepts sample 0 of a line also emits a front padding pair, with `out_approx` = 0 and `out_detail` = 0. This pair is pair 0 of the padded line.
- R7: At the next enabled edge after the edge that accepts a line's last sample, the block emits a back padding pair (0, 0). During that enabled cycle, `in_valid` must be low.
- R8: Pairs are numbered from 0 at the front padding pair. `out_eow` is high together with `out_valid` on every pair whose number is one less than a multiple of `WIN_LEN/2`, and on the back padding pair. For 26-sample lines and 10-sample windows, these are pairs 4, 9 and 14.
- R9: While `enable` is low, `in_valid` and `in_sample` are ignored, `out_valid` is low in the following cycle, and the block's pairing state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block-wide clock enable |
| in_valid | input | 1 | Sample strobe, honoured only with `enable` |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe per coefficient pair |
| out_approx | output | SAMPLE_W | Signed approximation coefficient |
| out_detail | output | SAMPLE_W+1 | Signed detail coefficient |
| out_eow | output | 1 | Marks the last pair of a window |

## Verification
The bench builds the block with `SAMPLE_W` = 8, `LINE_LEN` = 26 and `WIN_LEN` = 10. This gives a 30-sample padded line of three windows, and the bench runs several consecutive lines.

The narrow sample width lets the bench reach the extreme pairs (127, −128) and (−128, 127) directly. These pairs produce details of ±255 and exercise the floor rounding of negative odd details.

The short line makes every window boundary, both padding pairs and the line-to-line restart occur many times in a short run. These events are mixed with randomly gated `enable` and `in_valid`.

// File: rtl/hlw_pkg.sv
package hlw_pkg;

  // Which slot the next accepted sample fills.
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  // Kind of pair leaving the output stage.
  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_REAL  = 2'd1,
    PK_FRONT = 2'd2,
    PK_BACK  = 2'd3
  } pair_kind_e;

endpackage

// File: rtl/hlw_split_ctrl.sv
module hlw_split_ctrl
  import hlw_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LINE_LEN = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic [SAMPLE_W-1:0] even_smp,
  output logic [SAMPLE_W-1:0] odd_smp,
  output logic                pair_go,
  output logic                line_head,
  output logic                line_tail
);

  localparam int POS_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_LEN - 1);

  logic                acc;
  phase_e              ph_q, ph_d;
  logic [POS_W-1:0]    pos_q, pos_d;
  logic [SAMPLE_W-1:0] even_q, even_d;

  // next-state
  always_comb begin
    acc    = enable & in_valid;
    ph_d   = ph_q;
    pos_d  = pos_q;
    even_d = even_q;
    if (acc) begin
      pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      if (ph_q == PH_EVEN) begin
        even_d = in_sample;
        ph_d   = PH_ODD;
      end else begin
        ph_d   = PH_EVEN;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_EVEN;
      pos_q  <= '0;
      even_q <= '0;
    end else if (acc) begin
      ph_q   <= ph_d;
      pos_q  <= pos_d;
      even_q <= even_d;
    end
  end

  assign even_smp  = even_q;
  assign odd_smp   = in_sample;
  assign pair_go   = acc & (ph_q == PH_ODD);
  assign line_head = acc & (pos_q == '0);
  assign line_tail = pair_go & (pos_q == POS_LAST);

  AST_HEAD_IS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    line_head |-> ph_q == PH_EVEN); // R2
  AST_PAIR_THEN_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    pair_go |=> ph_q == PH_EVEN); // R2

endmodule

// File: rtl/hlw_lift_pair.sv
module hlw_lift_pair #(
  parameter int SAMPLE_W = 12
) (
  input  logic [SAMPLE_W-1:0] even_smp,
  input  logic [SAMPLE_W-1:0] odd_smp,
  output logic [SAMPLE_W:0]   detail,
  output logic [SAMPLE_W-1:0] approx,
  output logic                approx_ovf
);

  logic signed [SAMPLE_W:0] e_x, o_x, d_s, half_s, sum_s;

  always_comb begin
    e_x    = $signed({even_smp[SAMPLE_W-1], even_smp});
    o_x    = $signed({odd_smp[SAMPLE_W-1], odd_smp});
    // predict: odd corrected by its even neighbour
    d_s    = o_x - e_x;
    // update: works on the detail, sign-extending halving
    half_s = d_s >>> 1;
    sum_s  = e_x + half_s;
    detail     = d_s;
    approx     = sum_s[SAMPLE_W-1:0];
    approx_ovf = sum_s[SAMPLE_W] ^ sum_s[SAMPLE_W-1];
  end

endmodule

// File: rtl/hlw_out_stage.sv
module hlw_out_stage
  import hlw_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int WIN_LEN  = 10,
  parameter int LINE_LEN = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                pair_go,
  input  logic                line_head,
  input  logic                line_tail,
  input  logic [SAMPLE_W-1:0] approx,
  input  logic [SAMPLE_W:0]   detail,
  output logic                tail_pend,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_approx,
  output logic [SAMPLE_W:0]   out_detail,
  output logic                out_eow
);

  localparam int PAD_PAIRS  = 1;
  localparam int WIN_PAIRS  = WIN_LEN / 2;
  localparam int LINE_PAIRS = LINE_LEN / 2 + 2 * PAD_PAIRS;
  localparam int WC_W = (WIN_PAIRS > 1) ? $clog2(WIN_PAIRS) : 1;
  localparam int LC_W = $clog2(LINE_PAIRS + 1);
  localparam logic [WC_W-1:0] WIN_LAST  = WC_W'(WIN_PAIRS - 1);
  localparam logic [LC_W-1:0] LINE_LAST = LC_W'(LINE_PAIRS - 1);

  pair_kind_e          kind;
  logic                emit, emit_pad, eow_now;
  logic [WC_W-1:0]     win_idx, win_q, win_d;
  logic [LC_W-1:0]     line_idx, line_q, line_d;
  logic                tail_q, tail_d;
  logic                valid_d, eow_d;
  logic [SAMPLE_W-1:0] appr_q, appr_d;
  logic [SAMPLE_W:0]   det_q, det_d;

  // next-state
  always_comb begin
    if (pair_go)                  kind = PK_REAL;
    else if (enable && line_head) kind = PK_FRONT;
    else if (enable && tail_q)    kind = PK_BACK;
    else                          kind = PK_NONE;
    emit     = (kind != PK_NONE);
    emit_pad = (kind == PK_FRONT) || (kind == PK_BACK);

    win_idx  = line_head ? '0 : win_q;
    line_idx = line_head ? '0 : line_q;
    eow_now  = (win_idx == WIN_LAST) || (line_idx == LINE_LAST);

    win_d  = win_q;
    line_d = line_q;
    if (emit) begin
      win_d  = eow_now ? '0 : win_idx + 1'b1;
      line_d = (line_idx == LINE_LAST) ? '0 : line_idx + 1'b1;
    end

    tail_d = tail_q;
    if (line_tail)            tail_d = 1'b1;
    else if (kind == PK_BACK) tail_d = 1'b0;

    valid_d = emit;
    eow_d   = emit & eow_now;
    appr_d  = appr_q;
    det_d   = det_q;
    if (kind == PK_REAL) begin
      appr_d = approx;
      det_d  = detail;
    end else if (emit_pad) begin
      appr_d = '0;
      det_d  = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      line_q <= '0;
      tail_q <= 1'b0;
    end else if (enable) begin
      win_q  <= win_d;
      line_q <= line_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_eow   <= 1'b0;
      appr_q    <= '0;
      det_q     <= '0;
    end else begin
      out_valid <= valid_d;
      out_eow   <= eow_d;
      appr_q    <= appr_d;
      det_q     <= det_d;
    end
  end

  assign out_approx = appr_q;
  assign out_detail = det_q;
  assign tail_pend  = tail_q;

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    emit_pad |=> (out_approx == '0) && (out_detail == '0) && out_valid); // R6
  AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_go |-> !(line_head || tail_q)); // R5
  AST_EOW_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_eow |-> out_valid); // R8
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !out_valid); // R9

endmodule

// File: rtl/haar_lift_window.sv
module haar_lift_window #(
  parameter int SAMPLE_W = 12,
  parameter int WIN_LEN  = 10,
  parameter int LINE_LEN = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_approx,
  output logic [SAMPLE_W:0]   out_detail,
  output logic                out_eow
);

  logic [SAMPLE_W-1:0] even_smp, odd_smp, approx;
  logic [SAMPLE_W:0]   detail;
  logic                pair_go, line_head, line_tail, approx_ovf, tail_pend;

  hlw_split_ctrl #(
    .SAMPLE_W(SAMPLE_W),
    .LINE_LEN(LINE_LEN)
  ) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .even_smp (even_smp),
    .odd_smp  (odd_smp),
    .pair_go  (pair_go),
    .line_head(line_head),
    .line_tail(line_tail)
  );

  hlw_lift_pair #(
    .SAMPLE_W(SAMPLE_W)
  ) u_lift (
    .even_smp  (even_smp),
    .odd_smp   (odd_smp),
    .detail    (detail),
    .approx    (approx),
    .approx_ovf(approx_ovf)
  );

  hlw_out_stage #(
    .SAMPLE_W(SAMPLE_W),
    .WIN_LEN (WIN_LEN),
    .LINE_LEN(LINE_LEN)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pair_go   (pair_go),
    .line_head (line_head),
    .line_tail (line_tail),
    .approx    (approx),
    .detail    (detail),
    .tail_pend (tail_pend),
    .out_valid (out_valid),
    .out_approx(out_approx),
    .out_detail(out_detail),
    .out_eow   (out_eow)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pair_go |-> !approx_ovf); // R4
  AST_LINE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_pend && enable) |-> !in_valid); // R7

endmodule

// File: tb/tb_haar_lift_window.sv
module tb_haar_lift_window;

  localparam int W     = 8;
  localparam int LINE  = 26;
  localparam int WIN   = 10;
  localparam int LPAIR = LINE / 2 + 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic               out_valid;
  logic [W-1:0]       out_approx;
  logic [W:0]         out_detail;
  logic               out_eow;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  haar_lift_window #(.SAMPLE_W(W), .WIN_LEN(WIN), .LINE_LEN(LINE)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_approx(out_approx),
    .out_detail(out_detail), .out_eow(out_eow)
  );

  // behavioural reference
  int m_pos, m_even, m_pair, m_kind;
  bit m_tail, m_prev_en;
  int exp_a, exp_d;
  bit exp_v, exp_e;

  function automatic int floor_half(int v);
    return (v >= 0) ? v / 2 : -((-v + 1) / 2);
  endfunction

  task automatic put(int a, int d, int kind);
    exp_v  = 1;
    exp_a  = a;
    exp_d  = d;
    exp_e  = ((m_pair % (WIN / 2)) == (WIN / 2 - 1)) || (m_pair == LPAIR - 1);
    m_kind = kind;
    m_pair = m_pair + 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_even = 0; m_pair = 0; m_tail = 0; m_kind = 0;
      exp_v = 0; exp_a = 0; exp_d = 0; exp_e = 0; m_prev_en = 0;
    end else begin
      exp_v = 0;
      exp_e = 0;
      m_prev_en = enable;
      if (enable) begin
        if (m_tail) begin
          put(0, 0, 2);
          m_tail = 0;
        end
        if (in_valid) begin
          if (m_pos % 2 == 0) begin
            if (m_pos == 0) begin
              m_pair = 0;
              put(0, 0, 1);
            end
            m_even = int'(in_sample);
          end else begin
            put(m_even + floor_half(int'(in_sample) - m_even),
                int'(in_sample) - m_even, 0);
            if (m_pos == LINE - 1) m_tail = 1;
          end
          m_pos = (m_pos + 1) % LINE;
        end
      end
    end
  end

  task automatic check_now();
    string tv;
    n_vec++;
    if (!rst_n) begin
      if (out_valid || out_eow || out_approx != '0 || out_detail != '0) begin
        n_bad++;
        $display("FAIL R1 reset outputs v=%0b e=%0b a=%0d d=%0d exp all 0",
                 out_valid, out_eow, out_approx, out_detail);
      end
      return;
    end
    if (!m_prev_en)       tv = "R9";
    else if (!exp_v)      tv = "R5";
    else if (m_kind == 1) tv = "R6";
    else if (m_kind == 2) tv = "R7";
    else                  tv = "R5";
    if (out_valid !== exp_v) begin
      n_bad++;
      $display("FAIL %s out_valid act=%0b exp=%0b", tv, out_valid, exp_v);
    end else if (exp_v) begin
      if (int'($signed(out_detail)) != exp_d) begin
        n_bad++;
        $display("FAIL %s detail act=%0d exp=%0d", (m_kind == 0) ? "R3 (R2 pairing)" : tv,
                 $signed(out_detail), exp_d);
      end
      if (int'($signed(out_approx)) != exp_a) begin
        n_bad++;
        $display("FAIL %s approx act=%0d exp=%0d", (m_kind == 0) ? "R4" : tv,
                 $signed(out_approx), exp_a);
      end
      if (out_eow !== exp_e) begin
        n_bad++;
        $display("FAIL R8 eow act=%0b exp=%0b", out_eow, exp_e);
      end
    end
  endtask

  task automatic cyc(bit en, bit v, int s);
    @(negedge clk);
    check_now();
    enable    = en;
    in_valid  = v;
    in_sample = W'(s);
  endtask

  // mode 0 ramp, 1 random, 2 extremes, 3 random with stalls
  task automatic send_line(int mode);
    for (int i = 0; i < LINE; i++) begin
      int s;
      case (mode)
        0: s = i * 5 - 60;
        1: s = $urandom_range(255) - 128;
        2: s = ((i % 4) < 2) ? ((i % 2 == 0) ? 127 : -128) : ((i % 2 == 0) ? -128 : 127);
        default: s = $urandom_range(255) - 128;
      endcase
      if (mode == 3) begin
        while ($urandom_range(2) == 0) begin
          // R9: garbage while disabled must be ignored
          if ($urandom_range(1) == 0) cyc(0, 1, $urandom_range(255) - 128);
          else                        cyc(1, 0, 0);
        end
      end
      cyc(1, 1, s);
    end
    cyc(1, 0, 0);  // R7: gap cycle for the back pad
    cyc(1, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);  // R1 under reset
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 1, 33);  // R9: disabled right after reset
    cyc(1, 0, 0);
    send_line(0);
    send_line(1);
    send_line(2);   // R3 R4 extremes
    send_line(3);
    send_line(3);
    send_line(0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule